// File: doc/BRIEF.md
# UART Receive Character Queue with Line Status

This block sits between the receive deserializer of a UART channel and the host register interface. Each received character arrives with a one-cycle valid strobe, together with three condition flags: break, framing error and parity error. Character and flags are stored together as one queue entry. A break character is always stored with a data value of zero.

The host has two read ports. Reading the receive data register removes the oldest entry. The data value is presented combinationally, and the entry is removed at the clock edge on which the read strobe is high. The line status byte is also combinational. Reading it never removes an entry. Its three condition bits describe the oldest entry, so software reads the status first and then the data.

The status byte also carries other information:
- a summary bit that stays set while any flagged entry remains anywhere in the queue;
- a sticky overrun bit for characters dropped because the queue was full;
- a data-ready bit;
- two transmitter status bits passed through from the transmit side.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: After reset the queue is empty, `rhr_data` is 0x00, and `lsr_data` bits 7, 4, 3, 2, 1 and 0 are all 0.
- R2: Entries leave in the order they were accepted. The queue accepts up to DEPTH (default 64) entries before it is full.
- R3: `rhr_data` shows the data byte of the oldest entry while the queue is not empty. A high `rhr_rd` removes that entry at the next rising clock edge.
- R4: `lsr_data` bit 4 is the break flag, bit 3 the framing flag and bit 2 the parity flag of the oldest entry. All three read 0 while the queue is empty.
- R5: `lsr_rd` never changes the queue contents or the order of entries.
- R6: `lsr_data` bit 7 is 1 while at least one stored entry has any flag set. It returns to 0 once the last such entry has been removed.
- R7: A character pushed with `wr_brk` high is stored with data 0x00, whatever `wr_data` holds.
- R8: `lsr_data` bit 0 is 1 exactly when the queue holds at least one entry.
- R9: `lsr_data` bit 6 equals `thr_empty AND tsr_empty`. Bit 5 equals `thr_empty`.
- R10: A push while the queue is full and no entry is being removed is discarded and sets `lsr_data` bit 1. That bit is cleared by an `lsr_rd` edge, except that a new overrun on the same edge keeps it set.
- R11: A push and a removal on the same edge are both applied, including when the queue is full. The error-entry count is adjusted by both.
- R12: `rhr_rd` while the queue is empty returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Receive-side push strobe |
| wr_data | input | 8 | Received character |
| wr_brk | input | 1 | Break condition for this character |
| wr_fe | input | 1 | Framing error for this character |
| wr_pe | input | 1 | Parity error for this character |
| rhr_rd | input | 1 | Host read of the receive data register (removes an entry) |
| rhr_data | output | 8 | Oldest character, 0x00 when empty |
| lsr_rd | input | 1 | Host read of the line status byte (clears overrun) |
| lsr_data | output | 8 | Line status byte |
| thr_empty | input | 1 | Transmit holding register is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |

## Verification
The bench places flagged entries behind clean ones and clean ones behind flagged ones. A design that latches the summary bit, or that decrements its error count on every removal, would then clear bit 7 too early or never clear it.

The bench fills the queue to exactly DEPTH and pushes once more. This shows whether the last slot is accepted, whether the extra character wrongly overwrites an entry, and whether overrun is raised.

Simultaneous push and removal are driven at full and at empty. So are a status read on the same edge as a new overrun, and removals from an empty queue. Each of these exposes off-by-one pointer errors and wrong priority between the set and clear of the sticky bit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rxq_entry_t;

  // Status byte bit positions (host software decodes these)
  localparam int LSR_DERR = 7;
  localparam int LSR_TEMT = 6;
  localparam int LSR_THRE = 5;
  localparam int LSR_BRK  = 4;
  localparam int LSR_FE   = 3;
  localparam int LSR_PE   = 2;
  localparam int LSR_OVR  = 1;
  localparam int LSR_DR   = 0;

  function automatic logic entry_flagged(rxq_entry_t e);
    return e.brk | e.fe | e.pe;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  rxq_entry_t    entry_i,
  input  logic          pop_i,
  output rxq_entry_t    head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          drop_o,
  output logic [CW-1:0] count_o
);

  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign pop_ok_o  = pop_i && !empty_o;
  assign push_ok_o = push_i && (!full_o || pop_ok_o);
  assign drop_o    = push_i && !push_ok_o;
  assign head_o    = mem[rptr_q];
  assign count_o   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok_o) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok_o)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({push_ok_o, pop_ok_o})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage array: no reset, written only through its enable
  always_ff @(posedge clk) begin
    if (push_ok_o) mem[wptr_q] <= entry_i;
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r10_full_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (cnt_q == CW'(DEPTH)));

  a_r12_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (cnt_q == '0));

  a_r11_full_swap_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full_o) |=> (cnt_q == CW'(DEPTH)));

endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] count_o,
  output logic          any_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i) cnt_d = cnt_q + 1'b1;
    if (dec_i && !inc_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign any_o   = (cnt_q != '0);

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i) |-> (cnt_q != '0));

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_set_i,
  input  logic       lsr_rd_i,
  input  logic       any_err_i,
  input  logic       nonempty_i,
  input  rxq_entry_t head_i,
  input  logic       thr_empty_i,
  input  logic       tsr_empty_i,
  output logic [7:0] lsr_o
);

  logic ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (lsr_rd_i)  ovr_d = 1'b0;
    if (ovr_set_i) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    lsr_o           = '0;
    lsr_o[LSR_DERR] = any_err_i;
    lsr_o[LSR_TEMT] = thr_empty_i & tsr_empty_i;
    lsr_o[LSR_THRE] = thr_empty_i;
    lsr_o[LSR_BRK]  = nonempty_i & head_i.brk;
    lsr_o[LSR_FE]   = nonempty_i & head_i.fe;
    lsr_o[LSR_PE]   = nonempty_i & head_i.pe;
    lsr_o[LSR_OVR]  = ovr_q;
    lsr_o[LSR_DR]   = nonempty_i;
  end

  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !lsr_rd_i) |=> ovr_q);

  a_r10_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_i && !ovr_set_i) |=> !ovr_q);

  a_r10_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set_i |=> ovr_q);

endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_brk,
  input  logic       wr_fe,
  input  logic       wr_pe,
  input  logic       rhr_rd,
  output logic [7:0] rhr_data,
  input  logic       lsr_rd,
  output logic [7:0] lsr_data,
  input  logic       thr_empty,
  input  logic       tsr_empty
);

  rxq_entry_t    in_entry, head;
  logic          empty, full, push_ok, pop_ok, drop;
  logic [CW-1:0] q_count, err_count;
  logic          any_err;

  always_comb begin
    in_entry.brk  = wr_brk;
    in_entry.fe   = wr_fe;
    in_entry.pe   = wr_pe;
    in_entry.data = wr_brk ? 8'h00 : wr_data;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (wr_valid),
    .entry_i  (in_entry),
    .pop_i    (rhr_rd),
    .head_o   (head),
    .empty_o  (empty),
    .full_o   (full),
    .push_ok_o(push_ok),
    .pop_ok_o (pop_ok),
    .drop_o   (drop),
    .count_o  (q_count)
  );

  rxq_errcnt #(.CW(CW)) u_errcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (push_ok && entry_flagged(in_entry)),
    .dec_i  (pop_ok && entry_flagged(head)),
    .count_o(err_count),
    .any_o  (any_err)
  );

  rxq_lsr u_lsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_set_i  (drop),
    .lsr_rd_i   (lsr_rd),
    .any_err_i  (any_err),
    .nonempty_i (!empty),
    .head_i     (head),
    .thr_empty_i(thr_empty),
    .tsr_empty_i(tsr_empty),
    .lsr_o      (lsr_data)
  );

  assign rhr_data = empty ? 8'h00 : head.data;

  a_r6_err_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= q_count);

  a_r5_status_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rhr_rd && !wr_valid) |=> $stable(q_count));

  a_r8_ready_matches_fill: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_data[LSR_DR] == (q_count != '0));

endmodule

// File: tb/uart_rx_status_fifo_bench.sv
module uart_rx_status_fifo_bench;

  localparam int DEPTH = 64;

  logic       clk, rst_n;
  logic       wr_valid, wr_brk, wr_fe, wr_pe, rhr_rd, lsr_rd;
  logic       thr_empty, tsr_empty;
  logic [7:0] wr_data, rhr_data, lsr_data;

  int n_vec, n_bad;
  bit finished;

  // scoreboard entry layout: {brk, fe, pe, data[7:0]}
  logic [10:0] sb_q[$];
  bit          exp_ovr;

  uart_rx_status_fifo #(.DEPTH(DEPTH)) u_uart_rx_status_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_brk(wr_brk), .wr_fe(wr_fe), .wr_pe(wr_pe), .rhr_rd(rhr_rd),
    .rhr_data(rhr_data), .lsr_rd(lsr_rd), .lsr_data(lsr_data),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] exp_lsr();
    logic [7:0] v;
    bit anyerr;
    anyerr = 0;
    foreach (sb_q[i]) if (sb_q[i][10:8] != 3'b000) anyerr = 1;
    v    = '0;
    v[7] = anyerr;
    v[6] = thr_empty & tsr_empty;
    v[5] = thr_empty;
    if (sb_q.size() > 0) v[4:2] = sb_q[0][10:8];
    v[1] = exp_ovr;
    v[0] = (sb_q.size() > 0);
    return v;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle; monitor part compares outputs against scoreboard
  task automatic step(string tag, bit push, logic [7:0] d, bit b, bit f, bit p,
                      bit rd, bit lrd);
    bit pop_ok, push_ok;
    @(negedge clk);
    wr_valid = push; wr_data = d; wr_brk = b; wr_fe = f; wr_pe = p;
    rhr_rd = rd; lsr_rd = lrd;
    #1;
    check8({tag, " rhr"}, rhr_data, (sb_q.size() > 0) ? sb_q[0][7:0] : 8'h00);
    check8({tag, " lsr"}, lsr_data, exp_lsr());
    @(posedge clk);
    pop_ok  = rd && (sb_q.size() > 0);
    push_ok = push && ((sb_q.size() < DEPTH) || pop_ok);
    if (pop_ok) void'(sb_q.pop_front());
    if (push_ok) sb_q.push_back({b, f, p, (b ? 8'h00 : d)});
    if (lrd) exp_ovr = 0;
    if (push && !push_ok) exp_ovr = 1;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; exp_ovr = 0; finished = 0;
    wr_valid = 0; wr_data = 0; wr_brk = 0; wr_fe = 0; wr_pe = 0;
    rhr_rd = 0; lsr_rd = 0; thr_empty = 1; tsr_empty = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check8("R1 reset rhr", rhr_data, 8'h00);
    check8("R1 reset lsr", lsr_data, 8'h60);
    @(negedge clk); rst_n = 1;
    idle("R1 after release");

    // R9 transmitter status combinations
    thr_empty = 1; tsr_empty = 0; idle("R9 thr only");
    thr_empty = 0; tsr_empty = 1; idle("R9 tsr only");
    thr_empty = 0; tsr_empty = 0; idle("R9 none");
    thr_empty = 1; tsr_empty = 1; idle("R9 both");

    // R12 read of empty queue
    step("R12 empty read", 0, 8'h00, 0, 0, 0, 1, 0);
    idle("R12 still empty");

    // R2 R3 R8 clean ordering, R5 status reads in between
    for (int i = 0; i < 5; i++) step("R2 push clean", 1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R5 status read", 0, 8'h00, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) step("R3 R8 drain", 0, 8'h00, 0, 0, 0, 1, 0);

    // R4 R6 R7 flagged entries mixed with clean ones
    step("R6 push clean", 1, 8'hA1, 0, 0, 0, 0, 0);
    step("R4 push fe",    1, 8'hA2, 0, 1, 0, 0, 0);
    step("R6 push clean", 1, 8'hA3, 0, 0, 0, 0, 0);
    step("R4 push pe",    1, 8'hA4, 0, 0, 1, 0, 0);
    step("R7 push brk",   1, 8'h5A, 1, 0, 0, 0, 0);
    step("R6 push clean", 1, 8'hA6, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) step("R4 R6 R7 drain", 0, 8'h00, 0, 0, 0, 1, 0);

    // R11 simultaneous push and pop at empty and partly full
    step("R11 push pop empty", 1, 8'h33, 0, 1, 1, 1, 0);
    step("R11 push pop one",   1, 8'h34, 0, 0, 0, 1, 0);
    step("R11 drain", 0, 8'h00, 0, 0, 0, 1, 0);

    // R2 R10 fill to capacity and overrun
    for (int i = 0; i < DEPTH; i++)
      step("R2 fill", 1, 8'(i), (i == 5), (i == 9), 0, 0, 0);
    step("R10 push full", 1, 8'hEE, 0, 1, 0, 0, 0);
    idle("R10 ovr visible");
    step("R10 ovr set vs clear", 1, 8'hEF, 0, 0, 0, 0, 1);
    step("R10 clear read", 0, 8'h00, 0, 0, 0, 0, 1);
    idle("R10 ovr cleared");

    // R11 swap while full
    step("R11 swap full", 1, 8'hC7, 0, 0, 1, 1, 0);
    idle("R11 still full");

    // R2 drain everything in order, then read empty
    for (int i = 0; i < DEPTH + 2; i++) step("R2 R6 drain", 0, 8'h00, 0, 0, 0, 1, 0);
    idle("R12 end empty");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule